// File: doc/BRIEF.md
# Static Memory Bank Read Sequencer

This block turns a synchronous read request into a read cycle on one bank of asynchronous ROM, flash or SRAM. It places the address on the bank, lowers an active-low chip select and then an active-low output enable. It captures the read data after a programmed number of bus clocks and hands it back with a one-cycle done pulse. Every phase length is counted in bus clocks. Each phase is set by its own field in a 15-bit timing register, and each field uses a nonlinear code.

In page mode, the first item of a request takes a full access. The block then keeps chip select and output enable low and steps the low address bits, wrapping inside the page. Each further item is captured after the shorter page access time. A read-only status field holds the data-bus width and byte order. These are taken from strap pins while reset is held.

The sequencer is a single state machine with seven states:
- IDLE: waiting for a request.
- ASET: address driven, chip select high.
- CSET: chip select low, output enable high.
- ACC: first access.
- PAGE: each further page item.
- CHOLD: output enable high, chip select still low.
- AHOLD: chip select high, address held.

A state whose programmed length is zero is skipped. The transitions are:
- IDLE goes to ASET, CSET or ACC when a request is taken.
- ASET goes to CSET or ACC.
- CSET goes to ACC.
- ACC and PAGE go to PAGE while page items remain. Otherwise they go to CHOLD, AHOLD or IDLE.
- CHOLD goes to AHOLD or IDLE.
- AHOLD goes to IDLE.

Top module: `membank_rd_seq`

## Requirements
- R1: The address set-up field (register bits [14:13]; codes 0,1,2,3 give 0,1,2,4 clocks) sets how many cycles the address is held with chip select still high.
- R2: The chip-select set-up field (bits [12:11], same 0/1/2/4 decoding) sets how many cycles chip select is low before output enable falls.
- R3: The access field (bits [10:8]; codes 0..7 give 1,2,3,4,6,8,10,14 clocks) sets how long output enable is low before the first capture. On the last access clock the data on `mem_rdata` is captured, and `rd_done` is high for exactly one cycle in the following cycle.
- R4: The chip-select hold field (bits [7:6]) and the address hold field (bits [5:4]) both use 0/1/2/4 clocks. They set how long chip select stays low after output enable rises, and how long the bank stays busy with chip select high afterwards. The address does not change while chip select is low and output enable is high.
- R5: The page-size field (bits [1:0]; codes 0..3 give 1,4,8,16 items) sets how many items one request returns. The page access field (bits [3:2]; codes 0..3 give 2,3,4,6 clocks) sets the spacing of every item after the first. Chip select and output enable stay low between items. Item k is read from the request address with its low log2(items) bits replaced by (low bits + k) modulo items.
- R6: After reset the timing register reads 0x0700: access code 7 (14 clocks), every other field 0.
- R7: `stat_rdata` is {width[1:0], endian}, taken from the strap pins while reset is held. Strap pin changes after reset are ignored.
- R8: A write replaces the whole timing register, which then reads back the written value with the field layout given in R1 to R5.
- R9: `req_ready` is high only when the sequencer is idle. A request is taken only then, and `req_valid` pulses while busy are ignored.
- R10: A register write made during a read does not alter that read. It applies from the next request taken.
- R11: Output enable is never low while chip select is high. Both are high whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap pins are sampled while low |
| strap_width | input | 2 | Data-bus width strap: 00 8-bit, 01 16-bit, 10 32-bit, 11 test |
| strap_endian | input | 1 | Byte-order strap: 0 little, 1 big |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 15 | Timing register write value |
| cfg_rdata | output | 15 | Timing register contents |
| stat_rdata | output | 3 | {width, endian} latched at reset |
| req_valid | input | 1 | Read request |
| req_addr | input | AW | Read address |
| req_ready | output | 1 | High when idle and able to take a request |
| rd_done | output | 1 | One-cycle pulse per returned item |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | Address to the bank |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rdata | input | DW | Data from the bank |

## Verification
The assertions watch several bus-level rules on every clock:
- Output enable only ever falls inside a chip-select window, and both strobes are high while idle.
- The address is steady while chip select is low and output enable is high.
- Every done pulse follows a cycle with output enable low, and lasts one cycle.
- The status bits never move after reset.
- An idle sequencer with no request stays idle.

Only the bench scenarios can show the exact phase lengths for each field code, the data captured and its latency per item, and the wrapped address order in page mode. They also cover a register write landing mid-read and a request pulse that is ignored while busy.

// File: rtl/membank_pkg.sv
package membank_pkg;

    localparam int CFG_W = 15;
    localparam int CNT_W = 5;
    localparam logic [CFG_W-1:0] CFG_RESET = 15'h0700;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASET,
        ST_CSET,
        ST_ACC,
        ST_PAGE,
        ST_CHOLD,
        ST_AHOLD
    } seq_state_e;

    // field order is the register layout, MSB first
    typedef struct packed {
        logic [1:0] aset;
        logic [1:0] cset;
        logic [2:0] acc;
        logic [1:0] chold;
        logic [1:0] ahold;
        logic [1:0] pacc;
        logic [1:0] psize;
    } bank_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] aset;
        logic [CNT_W-1:0] cset;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] chold;
        logic [CNT_W-1:0] ahold;
        logic [CNT_W-1:0] pacc;
        logic [CNT_W-1:0] items;
    } bank_cnt_t;

    function automatic logic [CNT_W-1:0] dec_phase(input logic [1:0] code);
        return (code == 2'd3) ? CNT_W'(4) : CNT_W'(code);
    endfunction

    function automatic logic [CNT_W-1:0] dec_access(input logic [2:0] code);
        // 1,2,3,4 then steps of two up to 10, then 14
        if (code <= 3'd3)      return CNT_W'(code) + CNT_W'(1);
        else if (code == 3'd7) return CNT_W'(14);
        else                   return CNT_W'(2 * (code - 3'd1));
    endfunction

    function automatic logic [CNT_W-1:0] dec_page_access(input logic [1:0] code);
        return (code == 2'd3) ? CNT_W'(6) : CNT_W'(code) + CNT_W'(2);
    endfunction

    function automatic logic [CNT_W-1:0] dec_items(input logic [1:0] code);
        return (code == 2'd0) ? CNT_W'(1) : CNT_W'(2) << code;
    endfunction

    function automatic bank_cnt_t decode_cfg(input bank_cfg_t c);
        bank_cnt_t r;
        r.aset  = dec_phase(c.aset);
        r.cset  = dec_phase(c.cset);
        r.acc   = dec_access(c.acc);
        r.chold = dec_phase(c.chold);
        r.ahold = dec_phase(c.ahold);
        r.pacc  = dec_page_access(c.pacc);
        r.items = dec_items(c.psize);
        return r;
    endfunction

endpackage

// File: rtl/membank_cfg_regs.sv
module membank_cfg_regs
    import membank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic [1:0]       strap_width,
    input  logic             strap_endian,
    output bank_cfg_t        cfg_q,
    output logic [2:0]       stat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cfg_q <= bank_cfg_t'(CFG_RESET);
        else if (we) cfg_q <= bank_cfg_t'(wdata);
    end

    // strap capture follows the pins while reset is held, then freezes
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= {strap_width, strap_endian};
    end

endmodule

// File: rtl/membank_phase_timer.sv
module membank_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/membank_page_step.sv
module membank_page_step #(
    parameter int AW = 20,
    parameter int CW = 5
) (
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] items,
    output logic [AW-1:0] addr_out
);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        mask     = AW'(items) - AW'(1);
        inc      = addr_in + AW'(1);
        addr_out = (addr_in & ~mask) | (inc & mask);
    end

endmodule

// File: rtl/membank_rd_seq.sv
module membank_rd_seq
    import membank_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_width,
    input  logic             strap_endian,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [2:0]       stat_rdata,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output logic             rd_done,
    output logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    input  logic [DW-1:0]    mem_rdata
);

    bank_cfg_t        cfg_q;
    bank_cnt_t        live_cnt, snap_q, eff;
    seq_state_e       state_q, state_d, tail_st;
    logic             accept, sample, tmr_load, tmr_zero;
    logic [CNT_W-1:0] dur, left_q;
    logic [AW-1:0]    addr_q, addr_next;
    logic [DW-1:0]    data_q;
    logic             done_q;

    membank_cfg_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .wdata        (cfg_wdata),
        .strap_width  (strap_width),
        .strap_endian (strap_endian),
        .cfg_q        (cfg_q),
        .stat_q       (stat_rdata)
    );

    assign cfg_rdata = CFG_W'(cfg_q);
    assign live_cnt  = decode_cfg(cfg_q);
    // timings are frozen at accept; idle looks at the live register
    assign eff       = (state_q == ST_IDLE) ? live_cnt : snap_q;

    membank_phase_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dur - CNT_W'(1)),
        .zero     (tmr_zero)
    );

    membank_page_step #(.AW(AW), .CW(CNT_W)) i_step (
        .addr_in  (addr_q),
        .items    (snap_q.items),
        .addr_out (addr_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        sample  = 1'b0;
        if (eff.chold != '0)      tail_st = ST_CHOLD;
        else if (eff.ahold != '0) tail_st = ST_AHOLD;
        else                      tail_st = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (eff.aset != '0)      state_d = ST_ASET;
                    else if (eff.cset != '0) state_d = ST_CSET;
                    else                     state_d = ST_ACC;
                end
            end
            ST_ASET: begin
                if (tmr_zero) state_d = (eff.cset != '0) ? ST_CSET : ST_ACC;
            end
            ST_CSET: begin
                if (tmr_zero) state_d = ST_ACC;
            end
            ST_ACC, ST_PAGE: begin
                if (tmr_zero) begin
                    sample  = 1'b1;
                    state_d = (left_q > CNT_W'(1)) ? ST_PAGE : tail_st;
                end
            end
            ST_CHOLD: begin
                if (tmr_zero) state_d = (eff.ahold != '0) ? ST_AHOLD : ST_IDLE;
            end
            ST_AHOLD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // length of the state being entered
    always_comb begin
        unique case (state_d)
            ST_ASET:  dur = eff.aset;
            ST_CSET:  dur = eff.cset;
            ST_ACC:   dur = eff.acc;
            ST_PAGE:  dur = eff.pacc;
            ST_CHOLD: dur = eff.chold;
            ST_AHOLD: dur = eff.ahold;
            default:  dur = CNT_W'(1);
        endcase
        tmr_load = (state_d != state_q) || (sample && state_d == ST_PAGE);
    end

    // bus strobes
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:           req_ready = 1'b1;
            ST_CSET, ST_CHOLD: mem_cs_n  = 1'b0;
            ST_ACC, ST_PAGE: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            left_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= sample;
            if (accept) begin
                snap_q <= live_cnt;
                left_q <= live_cnt.items;
                addr_q <= req_addr;
            end
            if (sample) begin
                data_q <= mem_rdata;
                left_q <= left_q - CNT_W'(1);
                if (state_d == ST_PAGE) addr_q <= addr_next;
            end
        end
    end

    assign mem_addr = addr_q;
    assign rd_data  = data_q;
    assign rd_done  = done_q;

endmodule

// File: rtl/membank_rd_seq_chk.sv
module membank_rd_seq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rd_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic [2:0]    stat_rdata
);

    // R11
    oe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n));

    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n) && mem_oe_n && $past(mem_oe_n)) |-> $stable(mem_addr));

    // R3
    done_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(!mem_oe_n));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(stat_rdata));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);

endmodule

bind membank_rd_seq membank_rd_seq_chk #(.AW(AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_done    (rd_done),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .stat_rdata (stat_rdata)
);

// File: tb/test_membank_rd_seq.sv
module test_membank_rd_seq;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap_width = 2'b01;
    logic          strap_endian = 1'b1;
    logic          cfg_we = 1'b0;
    logic [14:0]   cfg_wdata = '0;
    logic [14:0]   cfg_rdata;
    logic [2:0]    stat_rdata;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rd_done, mem_cs_n, mem_oe_n;
    logic [DW-1:0] rd_data, mem_rdata;
    logic [AW-1:0] mem_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int acc_cyc = 0;

    logic [DW-1:0] q_data[$];
    int            q_lat[$];
    string         q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = (a * 20'd2654) ^ 20'h5A5A3;
        return t[DW-1:0];
    endfunction

    assign mem_rdata = (!mem_cs_n && !mem_oe_n) ? mem_fn(mem_addr) : '0;

    membank_rd_seq #(.AW(AW), .DW(DW)) i_membank_rd_seq (
        .clk(clk), .rst_n(rst_n), .strap_width(strap_width), .strap_endian(strap_endian),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rd_done(rd_done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every done pulse
    always @(negedge clk) begin
        if (rst_n && rd_done) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                logic [DW-1:0] ed;
                int el;
                string et;
                ed = q_data.pop_front();
                el = q_lat.pop_front();
                et = q_tag.pop_front();
                check(rd_data == ed, {et, " data"}, int'(rd_data), int'(ed));
                check(cyc - acc_cyc == el, {et, " latency"}, cyc - acc_cyc, el);
            end
        end
    end

    function automatic logic [14:0] pack_cfg(input int as, input int cs, input int ac,
                                             input int ch, input int ah, input int pa, input int ps);
        return 15'((as << 13) | (cs << 11) | (ac << 8) | (ch << 6) | (ah << 4) | (pa << 2) | ps);
    endfunction

    task automatic write_cfg(input logic [14:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == v, "R8 readback", int'(cfg_rdata), int'(v));
    endtask

    // a,c,t,p,h,ah in clocks; n items; optional mid-read write and stray request
    task automatic run_req(input logic [AW-1:0] addr, input int a, input int c, input int t,
                           input int p, input int n, input int h, input int ah, input string tag,
                           input bit mid_wr, input logic [14:0] mid_val, input bit stray);
        int busy = 0;
        int csl = 0;
        int oel = 0;
        logic [AW-1:0] m;
        m = AW'(n - 1);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] ak;
            ak = (addr & ~m) | ((addr + AW'(k)) & m);
            q_data.push_back(mem_fn(ak));
            q_lat.push_back(a + c + t + k * p);
            q_tag.push_back(tag);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr = addr;
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            if (!mem_cs_n) csl++;
            if (!mem_oe_n) oel++;
            cfg_we = (mid_wr && busy == 1);
            cfg_wdata = mid_val;
            req_valid = (stray && busy == 2);
            @(negedge clk);
        end
        cfg_we = 1'b0;
        req_valid = 1'b0;
        check(busy == a + c + t + (n - 1) * p + h + ah, {tag, " busy R4"}, busy,
              a + c + t + (n - 1) * p + h + ah);
        check(csl == c + t + (n - 1) * p + h, {tag, " cs-low R2"}, csl, c + t + (n - 1) * p + h);
        check(oel == t + (n - 1) * p, {tag, " oe-low R3"}, oel, t + (n - 1) * p);
        @(negedge clk);
        check(q_data.size() == 0, {tag, " items left R5"}, q_data.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset value, R7 straps, R11 idle strobes
        check(cfg_rdata == 15'h0700, "R6 reset cfg", int'(cfg_rdata), 'h700);
        check(stat_rdata == 3'b011, "R7 strap status", int'(stat_rdata), 3);
        check(mem_cs_n && mem_oe_n && req_ready, "R11 idle strobes", {mem_cs_n, mem_oe_n}, 3);
        strap_width = 2'b10;
        strap_endian = 1'b0;
        repeat (3) @(negedge clk);
        check(stat_rdata == 3'b011, "R7 straps ignored after reset", int'(stat_rdata), 3);

        // R6 slowest default access
        run_req(20'h00010, 0, 0, 14, 0, 1, 0, 0, "R6 default", 1'b0, '0, 1'b0);

        // R2 R3 example setting 0x1A00
        write_cfg(15'h1A00);
        run_req(20'h00123, 0, 4, 3, 0, 1, 0, 0, "R2 example", 1'b0, '0, 1'b0);

        // R1 R4 every phase present
        write_cfg(pack_cfg(3, 2, 4, 1, 3, 0, 0));
        check(cfg_rdata == 15'h7470, "R8 layout", int'(cfg_rdata), 'h7470);
        run_req(20'h0F00F, 4, 2, 6, 0, 1, 1, 4, "R1 all phases", 1'b0, '0, 1'b0);

        // R1 R2 R4 other codes
        write_cfg(pack_cfg(1, 1, 5, 2, 2, 0, 0));
        run_req(20'h00777, 1, 1, 8, 0, 1, 2, 2, "R4 codes", 1'b0, '0, 1'b0);

        // R5 page of 4, wrap inside page
        write_cfg(pack_cfg(0, 0, 1, 0, 0, 2, 1));
        run_req(20'h12346, 0, 0, 2, 4, 4, 0, 0, "R5 page4", 1'b0, '0, 1'b0);

        // R5 page of 16 with short page access
        write_cfg(pack_cfg(0, 0, 0, 0, 0, 0, 3));
        run_req(20'h0ABCF, 0, 0, 1, 2, 16, 0, 0, "R5 page16", 1'b0, '0, 1'b0);

        // R5 page of 8, 6-clock page access, with set-up and hold
        write_cfg(pack_cfg(1, 0, 2, 1, 0, 3, 2));
        run_req(20'h00035, 1, 0, 3, 6, 8, 1, 0, "R5 page8", 1'b0, '0, 1'b0);

        // R10 write mid-read, R9 stray request while busy
        write_cfg(15'h1A00);
        run_req(20'h04444, 0, 4, 3, 0, 1, 0, 0, "R10 mid write", 1'b1, 15'h0700, 1'b1);
        check(cfg_rdata == 15'h0700, "R10 new value stored", int'(cfg_rdata), 'h700);
        for (int i = 0; i < 3; i++) begin
            check(req_ready && mem_cs_n, "R9 stray ignored", {req_ready, mem_cs_n}, 3);
            @(negedge clk);
        end
        run_req(20'h05555, 0, 0, 14, 0, 1, 0, 0, "R10 next request", 1'b0, '0, 1'b0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule